// File: doc/BRIEF.md
# SIMT Divergence and Reconvergence Stack

This block keeps the control-flow state of one warp in a SIMT core with a small number of lanes. It holds a stack of entries. Each entry carries the PC at which its lanes join again, the PC those lanes fetch next, and a mask of the lanes it covers. The issue stage always takes the PC and lane mask of the topmost entry. The bottom entry covers every lane and has no join point.

Two kinds of event move the stack. A plain instruction completion supplies the next sequential PC. A resolved branch supplies the per-lane taken mask, the target PC, the fall-through PC and the join PC, which the compiler has encoded with the branch as the immediate post-dominator. A branch that all active lanes agree on only rewrites the top entry's next PC.

A split branch does three things:
- It points the top entry at the join PC.
- It pushes a fall-through entry.
- It pushes a taken entry on top of that.

When the next PC produced for the top entry equals that entry's join PC, the entry is removed, and issue continues from the entry underneath. An entry that is uncovered already sitting at its own join PC is removed on the following clock. Nested splits that share a join PC therefore unwind at one level per cycle.

Top module: `simt_reconv_stack`

## Requirements
- R1: Synchronous reset leaves a single base entry with next PC equal to START_PC and all lanes set. `issue_valid` is 1 and `ovf_err` is 0 on the first cycle after reset.
- R2: `issue_pc` and `issue_mask` always show the next PC and lane mask of the topmost entry.
- R3: With `adv_valid` high and no branch, the top entry's next PC becomes `adv_next_pc` one clock later. This does not apply when R6 pops the entry.
- R4: A branch is uniform when `br_taken_mask & issue_mask` is all zeros or equals `issue_mask`. A uniform branch sets the top entry's next PC to `br_fall_pc` (all zeros) or to `br_target_pc` (equal to `issue_mask`), and pushes nothing.
- R5: A branch that is not uniform, with at least two free entries, does three things:
  - It rewrites the top entry's next PC to `br_reconv_pc`.
  - It pushes an entry {join `br_reconv_pc`, next `br_fall_pc`, mask `issue_mask & ~br_taken_mask`}.
  - It then pushes {join `br_reconv_pc`, next `br_target_pc`, mask `issue_mask & br_taken_mask`}, so one clock later issue shows the target PC and the taken lanes.
- R6: If the next PC produced by R3 or R4 equals the top entry's join PC, that entry is removed instead of written. One clock later issue shows the entry beneath it unchanged.
- R7: An entry whose stored next PC equals its join PC drives `issue_valid` low and is removed at the next clock, regardless of `adv_valid` and `br_valid` in that cycle. Stacked entries in this state unwind one per cycle.
- R8: The base entry has no join PC and is never removed. Any PC written to it is simply stored, and while it is on top the mask is all ones.
- R9: A split branch with fewer than two free entries leaves the stack unchanged and sets `ovf_err`. `ovf_err` stays set until reset.
- R10: When `br_valid` and `adv_valid` are both high, the branch is applied and `adv_next_pc` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_valid | input | 1 | Non-branch instruction of the warp completed |
| adv_next_pc | input | PC_W | Next sequential PC for that instruction |
| br_valid | input | 1 | Branch of the warp resolved |
| br_taken_mask | input | LANES | Per-lane taken outcome |
| br_target_pc | input | PC_W | Branch target PC |
| br_fall_pc | input | PC_W | Fall-through PC |
| br_reconv_pc | input | PC_W | Join PC (immediate post-dominator) |
| issue_valid | output | 1 | Top entry may issue (low while it is being unwound) |
| issue_pc | output | PC_W | Next PC of the top entry |
| issue_mask | output | LANES | Lane mask of the top entry |
| ovf_err | output | 1 | Sticky flag: a split found no room |

## Verification
Every event lands in registers at the clock edge that samples it. Writes, pushes, pops and the overflow flag are therefore visible on the outputs exactly one edge after the inputs are presented. An entry exposed at its own join PC costs one further edge per level.

The bench drives inputs on the falling edge and advances its reference stack at that moment. It compares the outputs at the next falling edge, after exactly one rising edge has applied the event. Directed checks of the unwinding sequence and of the ignored inputs during a pending removal sample the cycle in which each level becomes visible.

// File: rtl/simt_stk_pkg.sv
package simt_stk_pkg;

    // Operation applied to the stack at the next clock edge
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_POP   = 2'd2,
        OP_SPLIT = 2'd3
    } stk_op_e;

    // Outcome of a branch across the active lanes
    typedef enum logic [1:0] {
        BR_NONE_TAKEN = 2'd0,
        BR_ALL_TAKEN  = 2'd1,
        BR_DIVERGE    = 2'd2
    } br_kind_e;

    // Bits needed to index a stack of the given depth
    function automatic int level_bits(input int depth);
        return (depth <= 2) ? 1 : $clog2(depth);
    endfunction

endpackage

// File: rtl/simt_br_classify.sv
module simt_br_classify
    import simt_stk_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic [LANES-1:0] taken_mask,
    input  logic [LANES-1:0] active_mask,
    output br_kind_e         kind,
    output logic [LANES-1:0] taken_lanes,
    output logic [LANES-1:0] fall_lanes
);

    always_comb begin
        taken_lanes = taken_mask & active_mask;
        fall_lanes  = active_mask & ~taken_mask;

        if (taken_lanes == '0) begin
            kind = BR_NONE_TAKEN;
        end else if (fall_lanes == '0) begin
            kind = BR_ALL_TAKEN;
        end else begin
            kind = BR_DIVERGE;
        end
    end

endmodule

// File: rtl/simt_stk_store.sv
module simt_stk_store
    import simt_stk_pkg::*;
#(
    parameter int               LANES    = 4,
    parameter int               PC_W     = 16,
    parameter int               DEPTH    = 8,
    parameter logic [PC_W-1:0]  START_PC = '0,
    parameter int               LVL_W    = level_bits(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  stk_op_e          op,
    input  logic [PC_W-1:0]  wr_pc,
    input  logic [PC_W-1:0]  split_rpc,
    input  logic [PC_W-1:0]  split_fall_pc,
    input  logic [LANES-1:0] split_fall_mask,
    input  logic [PC_W-1:0]  split_tgt_pc,
    input  logic [LANES-1:0] split_tgt_mask,
    output logic [PC_W-1:0]  top_npc,
    output logic [PC_W-1:0]  top_rpc,
    output logic             top_rpc_v,
    output logic [LANES-1:0] top_mask,
    output logic [LVL_W-1:0] tos
);

    typedef struct packed {
        logic             rpc_v;
        logic [PC_W-1:0]  rpc;
        logic [PC_W-1:0]  npc;
        logic [LANES-1:0] mask;
    } ent_t;

    localparam logic [LVL_W-1:0] LVL_ONE = LVL_W'(1);
    localparam logic [LVL_W-1:0] LVL_TWO = LVL_W'(2);

    logic [LVL_W-1:0] tos_q;
    logic [LVL_W-1:0] tos_p1;
    logic [LVL_W-1:0] tos_p2;
    ent_t             ent_rd [DEPTH];

    assign tos_p1 = tos_q + LVL_ONE;
    assign tos_p2 = tos_q + LVL_TWO;

    // One register per entry; each decodes its own write strobes
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        ent_t ent_r;
        logic is_top;
        logic is_push_fall;
        logic is_push_tgt;

        assign is_top       = (tos_q == LVL_W'(g));
        assign is_push_fall = (op == OP_SPLIT) && (tos_p1 == LVL_W'(g));
        assign is_push_tgt  = (op == OP_SPLIT) && (tos_p2 == LVL_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_r.rpc_v <= 1'b0;
                ent_r.rpc   <= '0;
                ent_r.npc   <= (g == 0) ? START_PC : '0;
                ent_r.mask  <= (g == 0) ? {LANES{1'b1}} : {LANES{1'b0}};
            end else if (is_top && op == OP_WRITE) begin
                ent_r.npc <= wr_pc;
            end else if (is_top && op == OP_SPLIT) begin
                ent_r.npc <= split_rpc;
            end else if (is_push_fall) begin
                ent_r.rpc_v <= 1'b1;
                ent_r.rpc   <= split_rpc;
                ent_r.npc   <= split_fall_pc;
                ent_r.mask  <= split_fall_mask;
            end else if (is_push_tgt) begin
                ent_r.rpc_v <= 1'b1;
                ent_r.rpc   <= split_rpc;
                ent_r.npc   <= split_tgt_pc;
                ent_r.mask  <= split_tgt_mask;
            end
        end

        assign ent_rd[g] = ent_r;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tos_q <= '0;
        end else begin
            case (op)
                OP_POP:   if (tos_q != '0) tos_q <= tos_q - LVL_ONE;
                OP_SPLIT: tos_q <= tos_p2;
                default:  tos_q <= tos_q;
            endcase
        end
    end

    always_comb begin
        top_npc   = ent_rd[tos_q].npc;
        top_rpc   = ent_rd[tos_q].rpc;
        top_rpc_v = ent_rd[tos_q].rpc_v;
        top_mask  = ent_rd[tos_q].mask;
    end

    assign tos = tos_q;

endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
    import simt_stk_pkg::*;
#(
    parameter int              LANES    = 4,
    parameter int              PC_W     = 16,
    parameter int              DEPTH    = 8,
    parameter logic [PC_W-1:0] START_PC = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv_valid,
    input  logic [PC_W-1:0]  adv_next_pc,
    input  logic             br_valid,
    input  logic [LANES-1:0] br_taken_mask,
    input  logic [PC_W-1:0]  br_target_pc,
    input  logic [PC_W-1:0]  br_fall_pc,
    input  logic [PC_W-1:0]  br_reconv_pc,
    output logic             issue_valid,
    output logic [PC_W-1:0]  issue_pc,
    output logic [LANES-1:0] issue_mask,
    output logic             ovf_err
);

    localparam int LVL_W = level_bits(DEPTH);

    logic [PC_W-1:0]  top_npc;
    logic [PC_W-1:0]  top_rpc;
    logic             top_rpc_v;
    logic [LANES-1:0] top_mask;
    logic [LVL_W-1:0] tos_q;

    br_kind_e         br_kind;
    logic [LANES-1:0] taken_lanes;
    logic [LANES-1:0] fall_lanes;

    stk_op_e          op;
    logic [PC_W-1:0]  wr_pc;
    logic             ovf_set;
    logic             ovf_q;
    logic             pending;
    logic             room;
    logic             join_hit;

    simt_br_classify #(
        .LANES (LANES)
    ) classify_i (
        .taken_mask  (br_taken_mask),
        .active_mask (top_mask),
        .kind        (br_kind),
        .taken_lanes (taken_lanes),
        .fall_lanes  (fall_lanes)
    );

    // Top entry already sits at its join point: it unwinds next edge
    assign pending  = top_rpc_v && (top_npc == top_rpc);
    // Two free slots above the current top
    assign room     = (int'(tos_q) + 2) <= (DEPTH - 1);
    assign join_hit = top_rpc_v && (wr_pc == top_rpc);

    always_comb begin
        op      = OP_NONE;
        wr_pc   = top_npc;
        ovf_set = 1'b0;

        if (pending) begin
            op = OP_POP;
        end else if (br_valid) begin
            case (br_kind)
                BR_NONE_TAKEN: wr_pc = br_fall_pc;
                BR_ALL_TAKEN:  wr_pc = br_target_pc;
                default:       wr_pc = top_npc;
            endcase
            if (br_kind == BR_DIVERGE) begin
                if (room) begin
                    op = OP_SPLIT;
                end else begin
                    ovf_set = 1'b1;
                end
            end else begin
                op = join_hit ? OP_POP : OP_WRITE;
            end
        end else if (adv_valid) begin
            wr_pc = adv_next_pc;
            op    = join_hit ? OP_POP : OP_WRITE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q <= 1'b0;
        end else if (ovf_set) begin
            ovf_q <= 1'b1;
        end
    end

    simt_stk_store #(
        .LANES    (LANES),
        .PC_W     (PC_W),
        .DEPTH    (DEPTH),
        .START_PC (START_PC),
        .LVL_W    (LVL_W)
    ) store_i (
        .clk             (clk),
        .rst             (rst),
        .op              (op),
        .wr_pc           (wr_pc),
        .split_rpc       (br_reconv_pc),
        .split_fall_pc   (br_fall_pc),
        .split_fall_mask (fall_lanes),
        .split_tgt_pc    (br_target_pc),
        .split_tgt_mask  (taken_lanes),
        .top_npc         (top_npc),
        .top_rpc         (top_rpc),
        .top_rpc_v       (top_rpc_v),
        .top_mask        (top_mask),
        .tos             (tos_q)
    );

    assign issue_valid = !pending;
    assign issue_pc    = top_npc;
    assign issue_mask  = top_mask;
    assign ovf_err     = ovf_q;

endmodule

// File: rtl/simt_reconv_stack_chk.sv
module simt_reconv_stack_chk
    import simt_stk_pkg::*;
#(
    parameter int              LANES    = 4,
    parameter int              PC_W     = 16,
    parameter int              DEPTH    = 8,
    parameter logic [PC_W-1:0] START_PC = '0,
    parameter int              LVL_W    = level_bits(DEPTH)
) (
    input logic             clk,
    input logic             rst,
    input logic             br_valid,
    input logic [LANES-1:0] br_taken_mask,
    input logic [PC_W-1:0]  br_target_pc,
    input logic             issue_valid,
    input logic [PC_W-1:0]  issue_pc,
    input logic [LANES-1:0] issue_mask,
    input logic             ovf_err,
    input logic [LVL_W-1:0] tos_q
);

    localparam logic [LVL_W-1:0] L1 = LVL_W'(1);
    localparam logic [LVL_W-1:0] L2 = LVL_W'(2);

    logic [LANES-1:0] tk;
    logic             split;
    logic             room;

    assign tk    = br_taken_mask & issue_mask;
    assign split = br_valid && issue_valid && (tk != '0) && (tk != issue_mask);
    assign room  = int'(tos_q) <= (DEPTH - 3);

    AST_RESET_BASE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (issue_pc == START_PC && issue_mask == {LANES{1'b1}} && !ovf_err && issue_valid)); // R1

    AST_BASE_FULL: assert property (@(posedge clk) disable iff (rst)
        (tos_q == '0) |-> (issue_valid && issue_mask == {LANES{1'b1}})); // R8

    AST_UNIFORM_FLAT: assert property (@(posedge clk) disable iff (rst)
        (br_valid && issue_valid && !split) |=> (tos_q <= $past(tos_q))); // R4

    AST_SPLIT_PUSH: assert property (@(posedge clk) disable iff (rst)
        (split && room) |=> (tos_q == $past(tos_q) + L2 && issue_pc == $past(br_target_pc)
                             && issue_mask == $past(tk))); // R5

    AST_PEND_UNWIND: assert property (@(posedge clk) disable iff (rst)
        !issue_valid |=> (tos_q == $past(tos_q) - L1)); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (split && !room) |=> (ovf_err && tos_q == $past(tos_q) && issue_pc == $past(issue_pc))); // R9

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf_err |=> ovf_err); // R9

endmodule

bind simt_reconv_stack simt_reconv_stack_chk #(
    .LANES    (LANES),
    .PC_W     (PC_W),
    .DEPTH    (DEPTH),
    .START_PC (START_PC)
) chk_i (
    .clk           (clk),
    .rst           (rst),
    .br_valid      (br_valid),
    .br_taken_mask (br_taken_mask),
    .br_target_pc  (br_target_pc),
    .issue_valid   (issue_valid),
    .issue_pc      (issue_pc),
    .issue_mask    (issue_mask),
    .ovf_err       (ovf_err),
    .tos_q         (tos_q)
);

// File: tb/simt_reconv_stack_tb_top.sv
module simt_reconv_stack_tb_top;

    localparam int         LANES = 4;
    localparam int         PC_W  = 8;
    localparam int         DEPTH = 5;
    localparam logic [7:0] START = 8'h10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       adv_valid = 1'b0;
    logic [7:0] adv_next_pc = '0;
    logic       br_valid = 1'b0;
    logic [3:0] br_taken_mask = '0;
    logic [7:0] br_target_pc = '0;
    logic [7:0] br_fall_pc = '0;
    logic [7:0] br_reconv_pc = '0;
    logic       issue_valid;
    logic [7:0] issue_pc;
    logic [3:0] issue_mask;
    logic       ovf_err;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    // Reference stack: index 0 is the base, last element is the top
    logic [7:0] q_npc [$];
    logic [7:0] q_rpc [$];
    logic [3:0] q_msk [$];
    bit         q_rv  [$];
    bit         m_ovf;

    always #10 clk = ~clk;

    simt_reconv_stack #(
        .LANES    (LANES),
        .PC_W     (PC_W),
        .DEPTH    (DEPTH),
        .START_PC (START)
    ) dut_i (
        .clk           (clk),
        .rst           (rst),
        .adv_valid     (adv_valid),
        .adv_next_pc   (adv_next_pc),
        .br_valid      (br_valid),
        .br_taken_mask (br_taken_mask),
        .br_target_pc  (br_target_pc),
        .br_fall_pc    (br_fall_pc),
        .br_reconv_pc  (br_reconv_pc),
        .issue_valid   (issue_valid),
        .issue_pc      (issue_pc),
        .issue_mask    (issue_mask),
        .ovf_err       (ovf_err)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic void model_reset();
        q_npc.delete(); q_rpc.delete(); q_msk.delete(); q_rv.delete();
        q_npc.push_back(START); q_rpc.push_back(8'h00);
        q_msk.push_back(4'hF);  q_rv.push_back(1'b0);
        m_ovf = 1'b0;
    endfunction

    function automatic void model_pop();
        void'(q_npc.pop_back()); void'(q_rpc.pop_back());
        void'(q_msk.pop_back()); void'(q_rv.pop_back());
    endfunction

    function automatic void model_apply(input bit bv, input logic [3:0] tk, input logic [7:0] tgt,
                                        input logic [7:0] fall, input logic [7:0] rpc,
                                        input bit av, input logic [7:0] apc);
        int         t = q_npc.size() - 1;
        logic [3:0] act;
        logic [7:0] newpc = 8'h00;
        bit         wr = 1'b0;
        if (q_rv[t] && q_npc[t] == q_rpc[t]) begin
            model_pop();
            return;
        end
        if (bv) begin
            act = tk & q_msk[t];
            if (act == 4'h0) begin
                newpc = fall; wr = 1'b1;
            end else if (act == q_msk[t]) begin
                newpc = tgt; wr = 1'b1;
            end else if (q_npc.size() + 2 > DEPTH) begin
                m_ovf = 1'b1;
            end else begin
                logic [3:0] m = q_msk[t];
                q_npc[t] = rpc;
                q_npc.push_back(fall); q_rpc.push_back(rpc);
                q_msk.push_back(m & ~tk); q_rv.push_back(1'b1);
                q_npc.push_back(tgt);  q_rpc.push_back(rpc);
                q_msk.push_back(m & tk);  q_rv.push_back(1'b1);
            end
        end else if (av) begin
            newpc = apc; wr = 1'b1;
        end
        if (wr) begin
            if (q_rv[t] && newpc == q_rpc[t]) model_pop();
            else q_npc[t] = newpc;
        end
    endfunction

    // Compare all outputs against the reference top of stack (R2, R7, R9)
    task automatic compare_model();
        int t = q_npc.size() - 1;
        check("R7 issue_valid", int'(issue_valid), int'(!(q_rv[t] && q_npc[t] == q_rpc[t])));
        check("R2 issue_pc",    int'(issue_pc),    int'(q_npc[t]));
        check("R2 issue_mask",  int'(issue_mask),  int'(q_msk[t]));
        check("R9 ovf_err",     int'(ovf_err),     int'(m_ovf));
    endtask

    // Called on a falling edge; returns on the next falling edge
    task automatic step(input bit bv, input logic [3:0] tk, input logic [7:0] tgt,
                        input logic [7:0] fall, input logic [7:0] rpc,
                        input bit av, input logic [7:0] apc);
        br_valid = bv; br_taken_mask = tk; br_target_pc = tgt;
        br_fall_pc = fall; br_reconv_pc = rpc;
        adv_valid = av; adv_next_pc = apc;
        model_apply(bv, tk, tgt, fall, rpc, av, apc);
        @(negedge clk);
        compare_model();
    endtask

    task automatic adv(input logic [7:0] pc);
        step(1'b0, 4'h0, 8'h00, 8'h00, 8'h00, 1'b1, pc);
    endtask

    task automatic br(input logic [3:0] tk, input logic [7:0] tgt,
                      input logic [7:0] fall, input logic [7:0] rpc);
        step(1'b1, tk, tgt, fall, rpc, 1'b0, 8'h00);
    endtask

    task automatic expect_top(input string tag, input bit v, input logic [7:0] pc,
                              input logic [3:0] m);
        check({tag, " valid"}, int'(issue_valid), int'(v));
        check({tag, " pc"},    int'(issue_pc),    int'(pc));
        check({tag, " mask"},  int'(issue_mask),  int'(m));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        br_valid = 1'b0; adv_valid = 1'b0;
        model_reset();
        repeat (2) @(negedge clk);
        rst = 1'b0;
        compare_model();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        expect_top("R1 reset", 1'b1, START, 4'hF);
        check("R1 ovf after reset", int'(ovf_err), 0);

        adv(8'h11);                       expect_top("R3 advance", 1'b1, 8'h11, 4'hF);
        br(4'hF, 8'h20, 8'h12, 8'h30);    expect_top("R4 all taken", 1'b1, 8'h20, 4'hF);
        br(4'h0, 8'h40, 8'h21, 8'h30);    expect_top("R4 none taken", 1'b1, 8'h21, 4'hF);
        step(1'b1, 4'h0, 8'h40, 8'h22, 8'h30, 1'b1, 8'h55);
        expect_top("R10 branch wins", 1'b1, 8'h22, 4'hF);
        adv(8'h00);                       expect_top("R8 base write", 1'b1, 8'h00, 4'hF);

        br(4'h9, 8'h40, 8'h50, 8'h60);    expect_top("R5 split", 1'b1, 8'h40, 4'h9);
        adv(8'h41);                       expect_top("R3 in path", 1'b1, 8'h41, 4'h9);
        br(4'hB, 8'h44, 8'h45, 8'h99);    expect_top("R4 uniform in path", 1'b1, 8'h44, 4'h9);
        adv(8'h60);                       expect_top("R6 pop taken path", 1'b1, 8'h50, 4'h6);
        adv(8'h60);                       expect_top("R6 pop to base", 1'b1, 8'h60, 4'hF);

        br(4'hE, 8'h70, 8'h80, 8'h80);    expect_top("R5 outer split", 1'b1, 8'h70, 4'hE);
        br(4'h6, 8'h71, 8'h72, 8'h80);    expect_top("R5 inner split", 1'b1, 8'h71, 4'h6);
        br(4'h2, 8'h75, 8'h76, 8'h77);    expect_top("R9 overflow", 1'b1, 8'h71, 4'h6);
        check("R9 overflow flag", int'(ovf_err), 1);
        adv(8'h80);                       expect_top("R6 inner pop", 1'b1, 8'h72, 4'h8);
        adv(8'h80);                       expect_top("R7 pending level 2", 1'b0, 8'h80, 4'hE);
        step(1'b0, 4'h0, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00);
        expect_top("R7 pending level 1", 1'b0, 8'h80, 4'h1);
        adv(8'h99);                       expect_top("R7 event ignored", 1'b1, 8'h80, 4'hF);
        check("R9 flag sticky", int'(ovf_err), 1);

        do_reset();
        check("R9 flag cleared by reset", int'(ovf_err), 0);

        for (int i = 0; i < 3000; i++) begin
            if (i % 500 == 499) begin
                do_reset();
            end else begin
                step($urandom_range(0, 2) == 0, 4'($urandom_range(0, 15)),
                     8'($urandom_range(0, 15)), 8'($urandom_range(0, 15)),
                     8'($urandom_range(0, 15)), $urandom_range(0, 1) == 1,
                     8'($urandom_range(0, 15)));
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule